// File: doc/BRIEF.md
# Multi-Channel General-Purpose Timer Bank

This block holds a bank of identical up-counting timer channels behind a plain word-addressed register port. Each channel has four registers: a control word, a tick-select word, a live counter and a compare value. On every tick the channel takes, its counter advances by one. When the counter already equals the compare value on a tick, the channel raises a compare event. What the channel does on that event depends on its mode: it stops, it restarts from zero, or, in free-run mode, there is no event and the counter keeps running.

Each channel picks one of two incoming tick strobes, fast or slow, and can optionally take only every second one. A shared enable register and a shared write-one-to-acknowledge register turn the per-channel pending flags into one level interrupt. Software uses the block as a set of event timers and free-running timestamps. It stops a channel with a read-modify-write of its control word.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset, every control, tick-select, counter and compare register reads 0, the interrupt enable reads 0, and irq_o is low.
- R2: Channel n (1..NUM_CH) decodes at byte offset 0x10*n. Its control word is at +0x0, tick select at +0x4, counter at +0x8 and compare at +0xC. The control word holds run enable in bit 0, a clear strobe in bit 1 and the mode in bits [5:4]. On read, bit 1 always returns 0 and the enable and mode return their stored values.
- R3: While a channel is enabled, its counter rises by one on each accepted tick. It holds when there is no tick or the channel is disabled. A write to the counter register loads the counter.
- R4: Tick-select bit 4 picks the fast strobe (0) or the slow strobe (1). Strobes on the other input have no effect. Bit 0 set means only every second selected strobe is accepted, counting from the last clear.
- R5: Mode 0 (one-shot): a tick taken while the counter equals compare sets the channel's pending flag and clears its run enable. The counter keeps the compare value.
- R6: Mode 1 (repeat): a tick taken while the counter equals compare sets the pending flag and reloads the counter to 0. The channel stays enabled.
- R7: Modes 3 and 2 (free-run): the counter wraps from all-ones to 0 and never sets the pending flag.
- R8: Writing the control word with bit 1 set zeroes the counter and the divide phase in the next cycle, whatever the run enable.
- R9: The interrupt enable register at 0x00 uses bit n-1 for channel n. irq_o is the OR over channels of pending AND enabled. The pending flag is set even when its enable bit is 0.
- R10: Writing the acknowledge register at 0x08 clears the pending flag of every channel whose bit (n-1) is 1. Bits written as 0 leave their flags unchanged. Writing 0x3F clears all six.
- R11: Clearing only the enable bit with a read-modify-write stops the counter and leaves the mode readable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| fast_tick_i | input | 1 | Fast tick strobe, one cycle per tick |
| slow_tick_i | input | 1 | Slow tick strobe, one cycle per tick |
| irq_o | output | 1 | Level interrupt |

## Verification
Reads are combinational, so a read issued half a cycle after a write sees the written value. Every register result therefore becomes visible right after the clock edge that captures the write or the tick strobe. The bench drives each write and each tick strobe at a falling edge and holds it for one cycle. It samples counter, control and irq_o only at a later falling edge, after the single register stage has updated. The expected counter, pending and enable values come from a bench function of mode, compare, divide and the number of selected strobes.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_RPT  = 2'd1,
    MODE_RSV  = 2'd2,
    MODE_FREE = 2'd3
  } mode_e;

  localparam logic [1:0] SUB_CTRL = 2'd0;
  localparam logic [1:0] SUB_TSEL = 2'd1;
  localparam logic [1:0] SUB_CNT  = 2'd2;
  localparam logic [1:0] SUB_CMP  = 2'd3;
endpackage

// File: rtl/gpt_tick_sel.sv
module gpt_tick_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  input  logic slow_i,
  input  logic src_i,
  input  logic div2_i,
  input  logic restart_i,
  output logic tick_o
);
  logic strobe, phase_q;

  assign strobe = src_i ? slow_i : fast_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= 1'b0;
    else if (restart_i)         phase_q <= 1'b0;
    else if (strobe && div2_i)  phase_q <= ~phase_q;
  end

  assign tick_o = strobe && (!div2_i || phase_q);
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             tsel_we_i,
  input  logic             cnt_we_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             fast_i,
  input  logic             slow_i,
  output logic [5:0]       ctrl_o,
  output logic [4:0]       tsel_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o
);
  logic             en_q, src_q, div_q;
  mode_e            mode_q;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             clr, tick, run, evt_mode;

  assign clr = ctrl_we_i && wdata_i[1];

  gpt_tick_sel u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fast_i   (fast_i),
    .slow_i   (slow_i),
    .src_i    (src_q),
    .div2_i   (div_q),
    .restart_i(clr),
    .tick_o   (tick)
  );

  assign run      = en_q && tick;
  assign evt_mode = (mode_q == MODE_ONCE) || (mode_q == MODE_RPT);
  assign hit_o    = run && evt_mode && (cnt_q == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= MODE_ONCE;
    end else if (ctrl_we_i) begin
      en_q   <= wdata_i[0];
      mode_q <= mode_e'(wdata_i[5:4]);
    end else if (hit_o && mode_q == MODE_ONCE) begin
      en_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b0;
      div_q <= 1'b0;
    end else if (tsel_we_i) begin
      src_q <= wdata_i[4];
      div_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cmp_q <= '0;
    else if (cmp_we_i)   cmp_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr)                cnt_q <= '0;
    else if (cnt_we_i)           cnt_q <= wdata_i;
    else if (hit_o) begin
      if (mode_q == MODE_RPT)    cnt_q <= '0;
    end
    else if (run)                cnt_q <= cnt_q + 1'b1;
  end

  assign ctrl_o = {mode_q, 2'b00, 1'b0, en_q};
  assign tsel_o = {src_q, 3'b000, div_q};
  assign cnt_o  = cnt_q;
  assign cmp_o  = cmp_q;

  // R5
  once_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && mode_q == MODE_ONCE && !ctrl_we_i && !cnt_we_i |=> !en_q && $stable(cnt_q));
  // R6
  rpt_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && mode_q == MODE_RPT && !ctrl_we_i && !cnt_we_i |=> cnt_q == '0 && en_q);
  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick && !ctrl_we_i && !cnt_we_i |=> $stable(cnt_q));
  // R8
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/gpt_irq.sv
module gpt_irq #(
  parameter int NUM_CH = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ien_we_i,
  input  logic              ack_we_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic [NUM_CH-1:0] hit_i,
  output logic [NUM_CH-1:0] ien_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] ien_q, pend_q, ack_mask;

  assign ack_mask = ack_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      if (ien_we_i) ien_q <= wdata_i;
      pend_q <= (pend_q & ~ack_mask) | hit_i;
    end
  end

  assign ien_o = ien_q;
  assign irq_o = |(pend_q & ien_q);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R9
    pend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[i]) |-> $past(hit_i[i]));
    // R10
    ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_we_i && wdata_i[i] && !hit_i[i] |=> !pend_q[i]);
  end
endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  output logic              irq_o
);
  localparam int CH_W = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] IEN_ADDR = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(8'h08);

  logic [NUM_CH-1:0] hit, ien;
  logic [5:0]        ctrl_r [NUM_CH];
  logic [4:0]        tsel_r [NUM_CH];
  logic [CNT_W-1:0]  cnt_r  [NUM_CH];
  logic [CNT_W-1:0]  cmp_r  [NUM_CH];
  logic [1:0]        sub;

  assign sub = addr_i[3:2];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic sel;
    assign sel = (addr_i[ADDR_W-1:4] == CH_W'(k + 1)) && (addr_i[1:0] == 2'b00) && wr_en_i;

    gpt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctrl_we_i(sel && sub == SUB_CTRL),
      .tsel_we_i(sel && sub == SUB_TSEL),
      .cnt_we_i (sel && sub == SUB_CNT),
      .cmp_we_i (sel && sub == SUB_CMP),
      .wdata_i  (wdata_i[CNT_W-1:0]),
      .fast_i   (fast_tick_i),
      .slow_i   (slow_tick_i),
      .ctrl_o   (ctrl_r[k]),
      .tsel_o   (tsel_r[k]),
      .cnt_o    (cnt_r[k]),
      .cmp_o    (cmp_r[k]),
      .hit_o    (hit[k])
    );
  end

  gpt_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ien_we_i(wr_en_i && addr_i == IEN_ADDR),
    .ack_we_i(wr_en_i && addr_i == ACK_ADDR),
    .wdata_i (wdata_i[NUM_CH-1:0]),
    .hit_i   (hit),
    .ien_o   (ien),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == IEN_ADDR) rdata_o = 32'(ien);
    for (int k = 0; k < NUM_CH; k++) begin
      if (addr_i[ADDR_W-1:4] == CH_W'(k + 1) && addr_i[1:0] == 2'b00) begin
        case (sub)
          SUB_CTRL: rdata_o = 32'(ctrl_r[k]);
          SUB_TSEL: rdata_o = 32'(tsel_r[k]);
          SUB_CNT:  rdata_o = 32'(cnt_r[k]);
          default:  rdata_o = 32'(cmp_r[k]);
        endcase
      end
    end
  end

  // R9
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien == '0 |-> !irq_o);
endmodule

// File: tb/sim_gp_timer_bank.sv
module sim_gp_timer_bank;
  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, fast = 1'b0, slow = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  gp_timer_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .fast_tick_i(fast), .slow_tick_i(slow), .irq_o(irq)
  );

  always #5ns clk = ~clk;

  function automatic logic [7:0] ra(input int ch, input int sub);
    return 8'(16 * ch + 4 * sub);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1ns d = rdata;
  endtask

  task automatic pulse(input logic f, input logic s);
    @(negedge clk); fast = f; slow = s;
    @(negedge clk); fast = 1'b0; slow = 1'b0;
  endtask

  // expected counter / pending / enable after e accepted strobes from a clear
  function automatic void model(input int mode, input int cmp, input int div, input int t,
                                output int cnt, output int pend, output int en);
    int e;
    e = div ? t / 2 : t;
    pend = 0; en = 1;
    if (mode == 0) begin
      if (e > cmp) begin cnt = cmp; pend = 1; en = 0; end else cnt = e;
    end else if (mode == 1) begin
      cnt = e % (cmp + 1); pend = (e > cmp) ? 1 : 0;
    end else cnt = e;
  endfunction

  initial begin
    #2ms;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0x0 exp=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int c = 1; c <= 6; c++) begin
      for (int s = 0; s < 4; s++) begin rd(ra(c, s), d); check("R1", d, 0); end
    end
    rd(8'h00, d); check("R1", d, 0);
    check("R1 irq", 32'(irq), 0);

    // R6 repeat on ch1, R2 readback, R8 clear reads 0
    wr(ra(1, 3), 2); wr(ra(1, 0), 32'h13); wr(8'h00, 32'h01);
    rd(ra(1, 0), d); check("R2 R8", d, 32'h11);
    repeat (3) pulse(1, 0);
    rd(ra(1, 2), d); check("R6 cnt", d, 0);
    check("R6 irq", 32'(irq), 1);
    pulse(1, 0);
    rd(ra(1, 2), d); check("R6 cnt", d, 1);
    rd(ra(1, 0), d); check("R6 en", d, 32'h11);
    wr(8'h08, 32'h01);
    #1ns check("R10 ack", 32'(irq), 0);
    wr(ra(1, 0), 32'h0);

    // R5 one-shot on ch2, R10 zero bits no effect
    wr(ra(2, 3), 1); wr(ra(2, 0), 32'h03); wr(8'h00, 32'h02);
    repeat (5) pulse(1, 0);
    rd(ra(2, 2), d); check("R5 cnt", d, 1);
    rd(ra(2, 0), d); check("R5 en", d, 0);
    check("R5 irq", 32'(irq), 1);
    wr(8'h08, 32'h3D);
    #1ns check("R10 zero bit", 32'(irq), 1);
    wr(8'h08, 32'h3F);
    #1ns check("R10 all", 32'(irq), 0);

    // R11 stop by read-modify-write on ch3
    wr(ra(3, 3), 100); wr(ra(3, 0), 32'h13);
    repeat (2) pulse(1, 0);
    rd(ra(3, 0), d); wr(ra(3, 0), d & ~32'h1);
    rd(ra(3, 0), d); check("R11 mode", d, 32'h10);
    pulse(1, 1);
    rd(ra(3, 2), d); check("R11 hold", d, 2);

    // R7 free-run wrap on ch4, R3 counter load
    wr(8'h00, 32'h08);
    wr(ra(4, 3), 0); wr(ra(4, 2), 32'hFFFF_FFFE);
    rd(ra(4, 2), d); check("R3 load", d, 32'hFFFF_FFFE);
    wr(ra(4, 0), 32'h31);
    repeat (3) pulse(1, 0);
    rd(ra(4, 2), d); check("R7 wrap", d, 1);
    check("R7 irq", 32'(irq), 0);
    wr(ra(4, 0), 32'h0);

    // R4 slow source with divide-by-two on ch5; fast strobes ignored
    wr(ra(5, 1), 32'h11); wr(ra(5, 3), 50); wr(ra(5, 0), 32'h13);
    repeat (4) pulse(1, 0);
    rd(ra(5, 2), d); check("R4 other src", d, 0);
    repeat (5) pulse(0, 1);
    rd(ra(5, 2), d); check("R4 div2", d, 2);
    wr(ra(5, 0), 32'h0);

    // R9 pending while masked, then unmask
    wr(8'h00, 32'h0); wr(8'h08, 32'h3F);
    wr(ra(6, 3), 0); wr(ra(6, 0), 32'h03);
    pulse(1, 0);
    check("R9 masked", 32'(irq), 0);
    wr(8'h00, 32'h20);
    #1ns check("R9 unmask", 32'(irq), 1);
    rd(8'h00, d); check("R9 ien", d, 32'h20);

    // random configurations
    for (int it = 0; it < 40; it++) begin
      int c, mode, cmp, src, div, t, n, ec, ep, ee;
      logic f, s;
      c = 1 + ($urandom % 6); mode = $urandom % 4; cmp = $urandom % 6;
      src = $urandom % 2; div = $urandom % 2; n = $urandom % 16; t = 0;
      wr(8'h00, 0); wr(8'h08, 32'h3F);
      wr(ra(c, 1), 32'((src << 4) | div));
      wr(ra(c, 3), 32'(cmp));
      wr(ra(c, 0), 32'((mode << 4) | 3));
      for (int p = 0; p < n; p++) begin
        f = 1'($urandom); s = 1'($urandom);
        if ((src ? s : f)) t++;
        pulse(f, s);
      end
      model(mode, cmp, div, t, ec, ep, ee);
      wr(8'h00, 32'(1 << (c - 1)));
      rd(ra(c, 2), d); check("R3 R5 R6 R7 rnd cnt", d, 32'(ec));
      check("R9 rnd irq", 32'(irq), 32'(ep));
      rd(ra(c, 0), d); check("R2 rnd ctrl", d, 32'((mode << 4) | ee));
      wr(ra(c, 0), 0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule